// File: doc/BRIEF.md
# Dual Shadow Register Checkpoint Engine

This block holds an architectural register file together with two shadow copies of the same size, one for each live speculative epoch. In normal operation the pipeline uses the main file through two synchronous read ports and one write port. When a checkpoint is requested, the engine stalls the pipeline. It then copies every register named in the valid mask into the shadow slot that currently holds the older saved state. That slot becomes the newest, and the older-slot pointer flips.

When a rollback is requested, the engine stalls the pipeline and copies the older valid checkpoint back into the main file. Only the registers that were saved with that checkpoint are rewritten. After a rollback, both slots are invalid until the next checkpoint. Every file has a single write port, so exactly one register moves per cycle, in ascending index order. Each operation ends with a single restore cycle, which raises the pipeline re-initialise pulse and the done pulse together and then returns to idle.

Top module: `ckpt_engine`

## Requirements
- R1: During and right after reset, stall_o, done_o and reinit_o are 0, slot_valid_o is 2'b00 and older_o is 0.
- R2: While idle, a read address presented at a clock edge returns that register's data after the edge (one cycle latency). A read and a write to the same register at the same edge return the old data. A write enable writes wr_data_i at wr_addr_i.
- R3: A checkpoint request sampled while idle raises stall_o from the next cycle. stall_o stays high for popcount(mask)+1 copy cycles plus one restore cycle. Pipeline writes presented while stall_o is high are ignored.
- R4: Only registers whose bit i in valid_mask_i is 1 (bit i selects register i, sampled with the request) are saved. They move one per cycle, in ascending index order. An all-zero mask still takes one copy cycle.
- R5: A checkpoint writes the slot named by older_o and clears that slot's valid bit on entry. When the operation ends, that slot is valid and older_o points at the other slot.
- R6: A rollback restores from slot older_o when that slot is valid, and otherwise from the only valid slot. Only the registers in that slot's saved mask are rewritten; all other registers keep their current values. Copy timing is the same as in R3.
- R7: When a rollback ends, slot_valid_o is 2'b00. A rollback request while no slot is valid is ignored: stall_o and done_o stay 0.
- R8: In the restore cycle, done_o and reinit_o are 1 for exactly one cycle. The next cycle is idle.
- R9: If both requests arrive in the same idle cycle and some slot is valid, the rollback is served and the checkpoint request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ckpt_req_i | input | 1 | Checkpoint request, sampled while idle |
| rollback_req_i | input | 1 | Rollback request, sampled while idle |
| valid_mask_i | input | NREGS | Registers to save; bit i selects register i |
| rd_a_addr_i | input | AW | Read port A address |
| rd_a_data_o | output | DW | Read port A data (not meaningful while stalled) |
| rd_b_addr_i | input | AW | Read port B address |
| rd_b_data_o | output | DW | Read port B data |
| wr_en_i | input | 1 | Pipeline write enable |
| wr_addr_i | input | AW | Pipeline write address |
| wr_data_i | input | DW | Pipeline write data |
| stall_o | output | 1 | Pipeline stall while the engine is busy |
| reinit_o | output | 1 | Pipeline re-initialise pulse |
| done_o | output | 1 | Operation complete pulse |
| older_o | output | 1 | Index of the older (next to overwrite) slot |
| slot_valid_o | output | 2 | Valid bit per shadow slot |

## Verification
A behavioural model predicts the stall window, the pulses, the slot state and every read, and the bench compares it with the block on each clock. Checkpoints are run with a full mask, a sparse mask and an empty mask. This separates a copy that honours the mask from one that copies everything, and shows that the cycle count follows the popcount. Rollbacks are run with both slots valid, with only the non-older slot valid, with no slot valid and together with a checkpoint request. These cases tell apart the choice of source slot, the invalidation rule and the priority. Pipeline writes are issued during stalls and then read back to show they had no effect.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAVE   = 2'd1,
    ST_LOAD   = 2'd2,
    ST_REINIT = 2'd3
  } ckpt_state_e;
endpackage

// File: rtl/ckpt_rf.sv
module ckpt_rf #(
  parameter int NREGS = 16,
  parameter int DW    = 32,
  parameter int NRD   = 2,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [AW-1:0]            waddr_i,
  input  logic [DW-1:0]            wdata_i,
  input  logic [NRD-1:0][AW-1:0]   raddr_i,
  output logic [NRD-1:0][DW-1:0]   rdata_o
);
  logic [DW-1:0] mem_q [NREGS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // registered read ports, old data on same-address write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
    end else begin
      for (int p = 0; p < NRD; p++) rdata_o[p] <= mem_q[raddr_i[p]];
    end
  end
endmodule

// File: rtl/ckpt_walker.sv
module ckpt_walker #(
  parameter int NREGS = 16,
  localparam int AW   = $clog2(NREGS),
  localparam int CW   = $clog2(NREGS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  input  logic [NREGS-1:0] mask_i,
  output logic [AW-1:0]    rd_addr_o,
  output logic             wr_en_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic             last_o
);
  logic [CW-1:0] cur_q;
  logic          pend_q;
  logic [AW-1:0] pend_addr_q;

  // lowest set mask bit at or above from; NREGS when none
  function automatic logic [CW-1:0] first_from(input logic [NREGS-1:0] m,
                                               input logic [CW-1:0] from);
    logic [CW-1:0] r;
    r = CW'(NREGS);
    for (int i = NREGS - 1; i >= 0; i--) begin
      if (m[i] && (CW'(i) >= from)) r = CW'(i);
    end
    return r;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q       <= CW'(NREGS);
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
    end else if (start_i) begin
      cur_q  <= first_from(mask_i, '0);
      pend_q <= 1'b0;
    end else if (run_i) begin
      if (cur_q != CW'(NREGS)) begin
        pend_q      <= 1'b1;
        pend_addr_q <= cur_q[AW-1:0];
        cur_q       <= first_from(mask_i, cur_q + 1'b1);
      end else begin
        pend_q <= 1'b0;
      end
    end
  end

  assign rd_addr_o = cur_q[AW-1:0];
  assign wr_en_o   = pend_q && run_i;
  assign wr_addr_o = pend_addr_q;
  assign last_o    = (cur_q == CW'(NREGS));

  p_ascending_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && $past(wr_en_o)) |-> (wr_addr_o > $past(wr_addr_o)));
endmodule

// File: rtl/ckpt_engine.sv
module ckpt_engine
  import ckpt_pkg::*;
#(
  parameter int NREGS = 16,
  parameter int DW    = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ckpt_req_i,
  input  logic             rollback_req_i,
  input  logic [NREGS-1:0] valid_mask_i,
  input  logic [AW-1:0]    rd_a_addr_i,
  output logic [DW-1:0]    rd_a_data_o,
  input  logic [AW-1:0]    rd_b_addr_i,
  output logic [DW-1:0]    rd_b_data_o,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic             stall_o,
  output logic             reinit_o,
  output logic             done_o,
  output logic             older_o,
  output logic [1:0]       slot_valid_o
);
  ckpt_state_e      state_q, state_d;
  logic             roll_q, slot_q, older_q;
  logic [1:0]       slot_valid_q;
  logic [NREGS-1:0] slot_mask_q [2];
  logic [NREGS-1:0] walk_mask_q;

  logic in_idle, any_valid, do_roll, do_ckpt, start, roll_src;
  logic [NREGS-1:0] start_mask, walk_mask;
  logic walking, walk_we, walk_last;
  logic [AW-1:0] walk_rd_addr, walk_wr_addr;

  assign in_idle    = (state_q == ST_IDLE);
  assign any_valid  = |slot_valid_q;
  assign do_roll    = in_idle && rollback_req_i && any_valid;
  assign do_ckpt    = in_idle && ckpt_req_i && !do_roll;
  assign start      = do_roll || do_ckpt;
  assign roll_src   = slot_valid_q[older_q] ? older_q : ~older_q;
  assign start_mask = do_roll ? slot_mask_q[roll_src] : valid_mask_i;
  assign walk_mask  = start ? start_mask : walk_mask_q;
  assign walking    = (state_q == ST_SAVE) || (state_q == ST_LOAD);

  ckpt_walker #(.NREGS(NREGS)) i_walker (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .run_i     (walking),
    .mask_i    (walk_mask),
    .rd_addr_o (walk_rd_addr),
    .wr_en_o   (walk_we),
    .wr_addr_o (walk_wr_addr),
    .last_o    (walk_last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (do_roll) state_d = ST_LOAD;
                 else if (do_ckpt) state_d = ST_SAVE;
      ST_SAVE,
      ST_LOAD:   if (walk_last) state_d = ST_REINIT;
      ST_REINIT: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= ST_IDLE;
      roll_q         <= 1'b0;
      slot_q         <= 1'b0;
      older_q        <= 1'b0;
      slot_valid_q   <= 2'b00;
      slot_mask_q[0] <= '0;
      slot_mask_q[1] <= '0;
      walk_mask_q    <= '0;
    end else begin
      state_q <= state_d;
      if (start) walk_mask_q <= start_mask;
      if (do_roll) begin
        roll_q <= 1'b1;
        slot_q <= roll_src;
      end else if (do_ckpt) begin
        roll_q <= 1'b0;
        slot_q <= older_q;
        slot_valid_q[older_q] <= 1'b0;  // old contents discarded
        slot_mask_q[older_q]  <= valid_mask_i;
      end
      if (state_q == ST_REINIT) begin
        if (roll_q) begin
          slot_valid_q <= 2'b00;
        end else begin
          slot_valid_q[slot_q] <= 1'b1;
          older_q <= ~slot_q;
        end
      end
    end
  end

  // register files
  logic [1:0][DW-1:0] main_rdata;
  logic [AW-1:0]      main_ra0;
  logic               main_we, main_eng_we;
  logic [AW-1:0]      main_waddr;
  logic [DW-1:0]      main_wdata;
  logic [DW-1:0]      sh_rdata [2];
  logic [1:0]         sh_we;

  assign main_ra0    = (state_q == ST_SAVE) ? walk_rd_addr : rd_a_addr_i;
  assign main_eng_we = (state_q == ST_LOAD) && walk_we;
  assign main_we     = (in_idle && wr_en_i) || main_eng_we;
  assign main_waddr  = (state_q == ST_LOAD) ? walk_wr_addr : wr_addr_i;
  assign main_wdata  = (state_q == ST_LOAD) ? sh_rdata[slot_q] : wr_data_i;

  ckpt_rf #(.NREGS(NREGS), .DW(DW), .NRD(2)) i_main_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (main_we),
    .waddr_i (main_waddr),
    .wdata_i (main_wdata),
    .raddr_i ({rd_b_addr_i, main_ra0}),
    .rdata_o (main_rdata)
  );

  for (genvar s = 0; s < 2; s++) begin : g_shadow
    assign sh_we[s] = (state_q == ST_SAVE) && walk_we && (slot_q == 1'(s));
    ckpt_rf #(.NREGS(NREGS), .DW(DW), .NRD(1)) i_shadow_rf (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (sh_we[s]),
      .waddr_i (walk_wr_addr),
      .wdata_i (main_rdata[0]),
      .raddr_i (walk_rd_addr),
      .rdata_o (sh_rdata[s])
    );
  end

  assign rd_a_data_o  = main_rdata[0];
  assign rd_b_data_o  = main_rdata[1];
  assign stall_o      = !in_idle;
  assign reinit_o     = (state_q == ST_REINIT);
  assign done_o       = (state_q == ST_REINIT);
  assign older_o      = older_q;
  assign slot_valid_o = slot_valid_q;

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !stall_o));
  p_noslot_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_idle && rollback_req_i && !any_valid && !ckpt_req_i) |=> !stall_o);
  p_roll_invalidates_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reinit_o && roll_q) |=> (slot_valid_o == 2'b00));
  p_single_writer_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sh_we, main_eng_we}));
  p_older_flip_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reinit_o && !roll_q) |=> (older_o != $past(older_o)));
  p_roll_priority_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_idle && rollback_req_i && ckpt_req_i && any_valid) |=> (state_q == ST_LOAD));
endmodule

// File: tb/test_ckpt_engine.sv
module test_ckpt_engine;
  localparam int N  = 16;
  localparam int DW = 32;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          ckpt_req, roll_req, wr_en;
  logic [N-1:0]  vmask;
  logic [AW-1:0] ra, rb, wa;
  logic [DW-1:0] wd, rda, rdb;
  logic          stall, reinit, done, older;
  logic [1:0]    svalid;

  ckpt_engine #(.NREGS(N), .DW(DW)) i_ckpt_engine (
    .clk_i(clk), .rst_ni(rst_n), .ckpt_req_i(ckpt_req), .rollback_req_i(roll_req),
    .valid_mask_i(vmask), .rd_a_addr_i(ra), .rd_a_data_o(rda),
    .rd_b_addr_i(rb), .rd_b_data_o(rdb), .wr_en_i(wr_en), .wr_addr_i(wa),
    .wr_data_i(wd), .stall_o(stall), .reinit_o(reinit), .done_o(done),
    .older_o(older), .slot_valid_o(svalid)
  );

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // reference model
  logic [DW-1:0] m_main [N];
  logic [DW-1:0] m_sh [2][N];
  logic [N-1:0]  m_smask [2];
  logic [1:0]    m_valid;
  logic          m_older, m_roll, m_slot;
  int            m_phase, m_left;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL R3 watchdog actual=%0d expected<=20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic cyc(input logic ck, input logic rq, input logic we,
                     input logic [AW-1:0] waddr, input logic [DW-1:0] wdata,
                     input logic [AW-1:0] a, input logic [AW-1:0] b,
                     input logic [N-1:0] msk, input string tag);
    logic [DW-1:0] ea, eb;
    logic chk_rd, src;
    @(negedge clk);
    ckpt_req = ck; roll_req = rq; wr_en = we; wa = waddr; wd = wdata;
    ra = a; rb = b; vmask = msk;
    @(posedge clk);
    chk_rd = (m_phase == 0);
    ea = m_main[a];
    eb = m_main[b];
    if (m_phase == 0) begin
      if (we) m_main[waddr] = wdata;
      if (rq && (m_valid != 2'b00)) begin
        src = m_valid[m_older] ? m_older : ~m_older;
        for (int i = 0; i < N; i++) if (m_smask[src][i]) m_main[i] = m_sh[src][i];
        m_roll = 1'b1; m_slot = src;
        m_phase = 1; m_left = $countones(m_smask[src]) + 1;
      end else if (ck) begin
        for (int i = 0; i < N; i++) if (msk[i]) m_sh[m_older][i] = m_main[i];
        m_smask[m_older] = msk;
        m_valid[m_older] = 1'b0;
        m_roll = 1'b0; m_slot = m_older;
        m_phase = 1; m_left = $countones(msk) + 1;
      end
    end else if (m_phase == 1) begin
      m_left--;
      if (m_left == 0) m_phase = 2;
    end else begin
      m_phase = 0;
      if (m_roll) m_valid = 2'b00;
      else begin
        m_valid[m_slot] = 1'b1;
        m_older = ~m_slot;
      end
    end
    #1;
    chk("R3 stall", DW'(stall), DW'(m_phase != 0));
    chk("R8 done", DW'(done), DW'(m_phase == 2));
    chk("R8 reinit", DW'(reinit), DW'(m_phase == 2));
    chk("R5 older", DW'(older), DW'(m_older));
    chk("R7 slot_valid", DW'(svalid), DW'(m_valid));
    if (chk_rd && !$isunknown(ea)) chk({tag, " rd_a"}, rda, ea);
    if (chk_rd && !$isunknown(eb)) chk({tag, " rd_b"}, rdb, eb);
  endtask

  task automatic idle_cyc(input string tag);
    cyc(1'b0, 1'b0, 1'b0, '0, '0, '0, '0, '0, tag);
  endtask

  // run until idle, offering pipeline writes that must be dropped (R3)
  task automatic drain(input string tag);
    for (int k = 0; k < 40 && m_phase != 0; k++)
      cyc(1'b0, 1'b0, 1'b1, AW'(k), 32'hDEAD_0000 + DW'(k), '0, '0, '0, tag);
    idle_cyc(tag);
  endtask

  task automatic fill(input int round);
    for (int i = 0; i < N; i++)
      cyc(1'b0, 1'b0, 1'b1, AW'(i), DW'(round * 4096 + i * 17 + 3) ^ 32'hA5A5_0000,
          AW'(i), AW'(N - 1 - i), '0, "R2");
    idle_cyc("R2");
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < N; i++) cyc(1'b0, 1'b0, 1'b0, '0, '0, AW'(i), AW'(N - 1 - i), '0, tag);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      m_main[i] = 'x; m_sh[0][i] = 'x; m_sh[1][i] = 'x;
    end
    m_smask[0] = '0; m_smask[1] = '0;
    m_valid = 2'b00; m_older = 1'b0; m_roll = 1'b0; m_slot = 1'b0;
    m_phase = 0; m_left = 0;
    ckpt_req = 0; roll_req = 0; wr_en = 0; wa = '0; wd = '0; ra = '0; rb = '0; vmask = '0;
    repeat (3) @(negedge clk);
    chk("R1 stall", DW'(stall), 0);
    chk("R1 done", DW'(done), 0);
    chk("R1 reinit", DW'(reinit), 0);
    chk("R1 slot_valid", DW'(svalid), 0);
    chk("R1 older", DW'(older), 0);
    rst_n = 1'b1;
    idle_cyc("R1");

    fill(1);
    read_all("R2");
    // same-address read and write returns old data
    cyc(1'b0, 1'b0, 1'b1, 4'd5, 32'h1234_5678, 4'd5, 4'd5, '0, "R2");
    cyc(1'b0, 1'b0, 1'b0, '0, '0, 4'd5, 4'd5, '0, "R2");

    // full checkpoint into slot 0
    cyc(1'b1, 1'b0, 1'b0, '0, '0, '0, '0, 16'hFFFF, "R5");
    drain("R3");
    read_all("R3");

    // sparse checkpoint into slot 1
    fill(2);
    cyc(1'b1, 1'b0, 1'b0, '0, '0, '0, '0, 16'h00F5, "R4");
    drain("R4");

    // rollback with both valid: slot 0 (older, full mask)
    fill(3);
    cyc(1'b0, 1'b1, 1'b0, '0, '0, '0, '0, '0, "R6");
    drain("R6");
    read_all("R6");

    // rollback with none valid is ignored
    cyc(1'b0, 1'b1, 1'b0, '0, '0, '0, '0, '0, "R7");
    idle_cyc("R7");
    idle_cyc("R7");

    // sparse save to slot 0, empty save to slot 1, then simultaneous requests
    fill(4);
    cyc(1'b1, 1'b0, 1'b0, '0, '0, '0, '0, 16'h0A0A, "R4");
    drain("R4");
    fill(5);
    cyc(1'b1, 1'b0, 1'b0, '0, '0, '0, '0, 16'h0000, "R4");
    drain("R4");
    fill(6);
    cyc(1'b1, 1'b1, 1'b0, '0, '0, '0, '0, 16'hFFFF, "R9");
    drain("R9");
    read_all("R9");

    // only the non-older slot valid: restore from it
    cyc(1'b1, 1'b0, 1'b0, '0, '0, '0, '0, 16'h8001, "R5");
    drain("R5");
    fill(7);
    cyc(1'b0, 1'b1, 1'b0, '0, '0, '0, '0, '0, "R6");
    drain("R6");
    read_all("R6");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule